// File: doc/BRIEF.md
# Three-State Write-Invalidate Snoop Controller

This block is the coherence controller that sits beside one copy-back, write-allocate cache on a shared snooping bus. It keeps a small direct-mapped array of tags and line states, where each line is Invalid, Valid or Dirty. Processor reads and writes are looked up in this array. A read that misses fetches the line over the bus. Every write, including one to a line that is already Dirty, broadcasts an invalidate and leaves the local line Dirty. A Dirty line that has to be evicted is written back, and the acknowledge for that write-back must arrive before the new transaction starts.

At the same time the controller watches what the other caches put on the bus. A foreign invalidate or write to a line held here removes the local copy. When a foreign read or write reaches a line that is Dirty here, the controller answers: it supplies the data and signals a memory update. After a foreign read it keeps the copy as Valid, and after a foreign write it drops the copy.

Data movement is reduced to handshakes and flags. Addresses are line addresses: the low `IDX_W` bits select the array entry and the remaining bits form the tag. Bus arbitration is outside the block. A snoop is therefore presented only while this controller is not driving a bus request.

Top module: `wi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `bus_req`, `cpu_done` and `snp_supply` are low. The first read of any address is a miss.
- R2: A processor read whose tag matches a Valid or Dirty line completes with `cpu_done` and `cpu_hit` high one cycle after it is accepted, with no bus request.
- R3: A processor read miss issues a bus read (`bus_op` = 1) carrying the requested address. After `bus_ack` the line holds the new tag as Valid and `cpu_done` pulses with `cpu_hit` low. Replacing a Valid line of another tag causes no write-back.
- R4: A processor write hit issues an invalidate (`bus_op` = 3) carrying the address. After `bus_ack` the line is Dirty and `cpu_done` pulses with `cpu_hit` low.
- R5: A processor write miss behaves like a write hit. It issues an invalidate for the address, and the line ends Dirty under the new tag.
- R6: A write to a line that is already Dirty issues the invalidate again.
- R7: A snooped invalidate (`snp_op` = 2) or write (`snp_op` = 1) whose tag matches a held line makes it Invalid. A snoop with a different tag at the same index changes nothing.
- R8: A snooped read (`snp_op` = 0) that matches a Dirty line raises `snp_supply` and `snp_mem_upd` for one cycle, in the cycle after the snoop, and the line becomes Valid. A snooped read of a Valid line produces no response.
- R9: A snooped write that matches a Dirty line raises `snp_supply` and `snp_mem_upd` for one cycle, in the cycle after the snoop, and the line becomes Invalid.
- R10: A miss that evicts a Dirty line of another tag first issues a write-back (`bus_op` = 2) carrying the victim's address. The request, opcode and address are held until `bus_ack`. Only after that does the read fill or invalidate start.
- R11: When a snoop and a processor request are present in the same cycle, the snoop is handled first. The processor request is accepted only afterwards and sees the line state the snoop left behind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor line address |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | With `cpu_done`: served locally with no bus transaction |
| bus_req | output | 1 | Bus transaction request, held until `bus_ack` |
| bus_op | output | 2 | 1 read fill, 2 write-back, 3 invalidate |
| bus_addr | output | ADDR_W | Line address of the transaction |
| bus_ack | input | 1 | One-cycle completion of the current transaction |
| snp_valid | input | 1 | A foreign transaction is on the bus this cycle |
| snp_op | input | 2 | 0 read, 1 write, 2 invalidate |
| snp_addr | input | ADDR_W | Line address of the foreign transaction |
| snp_supply | output | 1 | This cache drives the line data |
| snp_mem_upd | output | 1 | Memory takes the supplied data |

## Verification
A scoreboard replays processor reads and writes in several patterns and checks every resulting event. Repeated reads separate hits from misses. Reads and writes to the same index with different tags separate a clean replacement from a write-back of a Dirty victim. Repeated writes confirm that an invalidate is issued every time. Each snoop kind is applied to Valid lines, Dirty lines and lines with a non-matching tag. A later read or a second snoop then shows the state each snoop left behind. Snoops that collide with a processor request in the same cycle show the ordering between the two paths.

// File: rtl/wi_snoop_pkg.sv
// Package: shared encodings for the write-invalidate snoop controller.
// Assumes nothing beyond the two-bit codes listed here.
package wi_snoop_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_VAL = 2'd1,
        LN_DRT = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_RD   = 2'd1,
        BUS_WB   = 2'd2,
        BUS_INV  = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        SNP_RD  = 2'd0,
        SNP_WR  = 2'd1,
        SNP_INV = 2'd2
    } snp_op_e;

endpackage

// File: rtl/wi_line_array.sv
// Tag and state storage, one entry per direct-mapped index.
// Two read ports serve the processor and the snoop lookups.
// The fill port writes a tag and a state; the snoop port writes a state only.
// When both ports write the same index in one cycle, the fill port wins.
module wi_line_array
    import wi_snoop_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] pa_idx,
    output logic [TAG_W-1:0] pa_tag,
    output line_st_e         pa_st,
    input  logic [IDX_W-1:0] sa_idx,
    output logic [TAG_W-1:0] sa_tag,
    output line_st_e         sa_st,
    input  logic             fw_en,
    input  logic [IDX_W-1:0] fw_idx,
    input  logic [TAG_W-1:0] fw_tag,
    input  line_st_e         fw_st,
    input  logic             sw_en,
    input  logic [IDX_W-1:0] sw_idx,
    input  line_st_e         sw_st
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] tag_v [LINES];
    line_st_e         st_v  [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [TAG_W-1:0] tag_q;
        line_st_e         st_q;
        logic             fsel;
        logic             ssel;

        assign fsel = fw_en && (fw_idx == IDX_W'(i));
        assign ssel = sw_en && (sw_idx == IDX_W'(i));

        // Update one entry: the fill port first, then the snoop port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q <= '0;
                st_q  <= LN_INV;
            end else if (fsel) begin
                tag_q <= fw_tag;
                st_q  <= fw_st;
            end else if (ssel) begin
                st_q <= sw_st;
            end
        end

        assign tag_v[i] = tag_q;
        assign st_v[i]  = st_q;
    end

    assign pa_tag = tag_v[pa_idx];
    assign pa_st  = st_v[pa_idx];
    assign sa_tag = tag_v[sa_idx];
    assign sa_st  = st_v[sa_idx];

endmodule

// File: rtl/wi_snoop_resp.sv
// Snoop side: decides the new state of a matching line for a foreign
// transaction, and registers the data-supply and memory-update response.
// Assumes the caller presents the stored tag and state of the snooped index.
module wi_snoop_resp
    import wi_snoop_pkg::*;
#(
    parameter int TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snp_valid,
    input  snp_op_e          snp_op,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic [TAG_W-1:0] line_tag,
    input  line_st_e         line_st,
    output logic             upd_en,
    output line_st_e         upd_st,
    output logic             supply_q,
    output logic             memupd_q
);
    logic match;
    logic give;

    assign match = snp_valid && (line_st != LN_INV) && (line_tag == snp_tag);

    // Choose the next line state and whether a copy-back answer is owed.
    always_comb begin
        upd_en = 1'b0;
        upd_st = line_st;
        give   = 1'b0;
        if (match) begin
            unique case (snp_op)
                SNP_RD: begin
                    if (line_st == LN_DRT) begin
                        upd_en = 1'b1;
                        upd_st = LN_VAL;
                        give   = 1'b1;
                    end
                end
                SNP_WR: begin
                    upd_en = 1'b1;
                    upd_st = LN_INV;
                    give   = (line_st == LN_DRT);
                end
                SNP_INV: begin
                    upd_en = 1'b1;
                    upd_st = LN_INV;
                end
                default: ;
            endcase
        end
    end

    // Register the one-cycle response pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            supply_q <= 1'b0;
            memupd_q <= 1'b0;
        end else begin
            supply_q <= give;
            memupd_q <= give;
        end
    end

endmodule

// File: rtl/wi_cpu_fsm.sv
// Processor side: looks up the request, issues write-back, fill or
// invalidate on the bus, and completes the request.
// Assumes the array's processor port is indexed by cpu_addr, which the
// requester holds stable until cpu_done. Requests are not accepted in a
// cycle with a snoop, nor in the cycle that shows a completion.
module wi_cpu_fsm
    import wi_snoop_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              snp_valid,
    input  logic [ADDR_W-IDX_W-1:0] look_tag,
    input  line_st_e          look_st,
    input  logic              bus_ack,
    output logic              bus_req,
    output bus_op_e           bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              cpu_done,
    output logic              cpu_hit,
    output logic              fw_en,
    output logic [IDX_W-1:0]  fw_idx,
    output logic [ADDR_W-IDX_W-1:0] fw_tag,
    output line_st_e          fw_st
);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef enum logic [1:0] {S_IDLE, S_WB, S_FILL, S_INV} fsm_e;

    fsm_e              st_q;
    logic              we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [TAG_W-1:0]  vic_q;
    logic              done_q;
    logic              hit_q;
    logic              accept;
    logic              tag_eq;
    logic              lhit;

    assign accept = (st_q == S_IDLE) && cpu_req && !snp_valid && !done_q;
    assign tag_eq = (look_tag == cpu_addr[ADDR_W-1:IDX_W]);
    assign lhit   = tag_eq && (look_st != LN_INV);

    // Sequence each request through lookup, optional write-back and fill or invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            we_q   <= 1'b0;
            addr_q <= '0;
            vic_q  <= '0;
            done_q <= 1'b0;
            hit_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            hit_q  <= 1'b0;
            unique case (st_q)
                S_IDLE: begin
                    if (accept) begin
                        we_q   <= cpu_we;
                        addr_q <= cpu_addr;
                        vic_q  <= look_tag;
                        if (!cpu_we && lhit) begin
                            done_q <= 1'b1;
                            hit_q  <= 1'b1;
                        end else if (look_st == LN_DRT && !tag_eq) begin
                            st_q <= S_WB;
                        end else begin
                            st_q <= cpu_we ? S_INV : S_FILL;
                        end
                    end
                end
                S_WB: begin
                    if (bus_ack) st_q <= we_q ? S_INV : S_FILL;
                end
                S_FILL, S_INV: begin
                    if (bus_ack) begin
                        st_q   <= S_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // Drive the bus request from the current state.
    always_comb begin
        bus_req  = 1'b1;
        bus_op   = BUS_IDLE;
        bus_addr = addr_q;
        unique case (st_q)
            S_WB:    begin bus_op = BUS_WB; bus_addr = {vic_q, addr_q[IDX_W-1:0]}; end
            S_FILL:  bus_op = BUS_RD;
            S_INV:   bus_op = BUS_INV;
            default: bus_req = 1'b0;
        endcase
    end

    // Write the new tag and state when the last transaction is acknowledged.
    always_comb begin
        fw_en  = bus_ack && (st_q == S_FILL || st_q == S_INV);
        fw_idx = addr_q[IDX_W-1:0];
        fw_tag = addr_q[ADDR_W-1:IDX_W];
        fw_st  = (st_q == S_INV) ? LN_DRT : LN_VAL;
    end

    assign cpu_done = done_q;
    assign cpu_hit  = hit_q;

endmodule

// File: rtl/wi_snoop_ctrl.sv
// Top: per-cache coherence controller with Invalid/Valid/Dirty lines.
// Joins the line array, the processor sequencer and the snoop responder.
// Assumes bus arbitration presents snoops only while bus_req is low.
module wi_snoop_ctrl
    import wi_snoop_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_done,
    output logic              cpu_hit,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_ack,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_supply,
    output logic              snp_mem_upd
);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [TAG_W-1:0] pa_tag, sa_tag, fw_tag;
    line_st_e         pa_st, sa_st, fw_st, sw_st;
    logic             fw_en, sw_en;
    logic [IDX_W-1:0] fw_idx;
    bus_op_e          op_e;

    wi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .pa_idx (cpu_addr[IDX_W-1:0]),
        .pa_tag (pa_tag),
        .pa_st  (pa_st),
        .sa_idx (snp_addr[IDX_W-1:0]),
        .sa_tag (sa_tag),
        .sa_st  (sa_st),
        .fw_en  (fw_en),
        .fw_idx (fw_idx),
        .fw_tag (fw_tag),
        .fw_st  (fw_st),
        .sw_en  (sw_en),
        .sw_idx (snp_addr[IDX_W-1:0]),
        .sw_st  (sw_st)
    );

    wi_cpu_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .snp_valid (snp_valid),
        .look_tag  (pa_tag),
        .look_st   (pa_st),
        .bus_ack   (bus_ack),
        .bus_req   (bus_req),
        .bus_op    (op_e),
        .bus_addr  (bus_addr),
        .cpu_done  (cpu_done),
        .cpu_hit   (cpu_hit),
        .fw_en     (fw_en),
        .fw_idx    (fw_idx),
        .fw_tag    (fw_tag),
        .fw_st     (fw_st)
    );

    wi_snoop_resp #(.TAG_W(TAG_W)) u_snoop (
        .clk       (clk),
        .rst_n     (rst_n),
        .snp_valid (snp_valid),
        .snp_op    (snp_op_e'(snp_op)),
        .snp_tag   (snp_addr[ADDR_W-1:IDX_W]),
        .line_tag  (sa_tag),
        .line_st   (sa_st),
        .upd_en    (sw_en),
        .upd_st    (sw_st),
        .supply_q  (snp_supply),
        .memupd_q  (snp_mem_upd)
    );

    assign bus_op = op_e;

endmodule

// File: rtl/wi_snoop_ctrl_chk.sv
// Checker: temporal properties on the ports of wi_snoop_ctrl, bound below.
// Assumes the synchronous active-low reset of the controller.
module wi_snoop_ctrl_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_done,
    input logic              cpu_hit,
    input logic              bus_req,
    input logic [1:0]        bus_op,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ack,
    input logic              snp_valid,
    input logic [1:0]        snp_op,
    input logic              snp_supply,
    input logic              snp_mem_upd
);
    // R1: a reset cycle leaves every output quiet.
    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (!bus_req && !cpu_done && !snp_supply && !snp_mem_upd));

    // R2: a locally served completion follows a cycle with no bus request.
    assert_hit_without_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && cpu_hit) |-> $past(!bus_req));

    // R3: a completion that used the bus follows an acknowledged fill or invalidate.
    assert_miss_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && !cpu_hit) |-> $past(bus_req && bus_ack && bus_op != 2'd2));

    // R4: an acknowledged invalidate completes the write in the next cycle.
    assert_inval_completes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && bus_op == 2'd3) |=> (cpu_done && !cpu_hit));

    // R8: every supply comes with a memory update and answers a read or write snoop.
    assert_supply_pairs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (snp_mem_upd && $past(snp_valid && snp_op != 2'd2)));

    // R9: a response lasts a single cycle.
    assert_supply_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |=> !snp_supply);

    // R10: a pending transaction holds its opcode and address until acknowledged.
    assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_op) && $stable(bus_addr)));

    // R10: an acknowledged write-back is followed by the fill or invalidate.
    assert_wb_then_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && bus_op == 2'd2) |=> (bus_req && bus_op != 2'd2));

    // R11: no processor completion in the cycle after a snoop is taken.
    assert_snoop_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !bus_req) |=> !cpu_done);

    // R11: snoops are only presented while the bus is free.
    assert_snoop_bus_free_R11: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !bus_req);

endmodule

bind wi_snoop_ctrl wi_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_done    (cpu_done),
    .cpu_hit     (cpu_hit),
    .bus_req     (bus_req),
    .bus_op      (bus_op),
    .bus_addr    (bus_addr),
    .bus_ack     (bus_ack),
    .snp_valid   (snp_valid),
    .snp_op      (snp_op),
    .snp_supply  (snp_supply),
    .snp_mem_upd (snp_mem_upd)
);

// File: tb/wi_snoop_ctrl_test.sv
// Scoreboard bench: driver tasks queue expected events, a monitor compares
// bus transactions, completions and snoop responses as they appear.
module wi_snoop_ctrl_test;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_done, cpu_hit, bus_req;
    logic [1:0]    bus_op;
    logic [AW-1:0] bus_addr;
    logic          bus_ack = 1'b0;
    logic          snp_valid = 1'b0;
    logic [1:0]    snp_op = 2'd0;
    logic [AW-1:0] snp_addr = '0;
    logic          snp_supply, snp_mem_upd;

    wi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(3)) uut (.*);

    always #10 clk = ~clk;

    typedef struct packed {
        logic [1:0]    kind;   // 0 bus, 1 done, 2 supply
        logic [1:0]    op;
        logic [AW-1:0] addr;
        logic          hit;
    } ev_t;

    ev_t   expq[$];
    int    nvec = 0;
    int    nbad = 0;
    string cur_req = "R1";
    bit    open = 1'b0;
    int    ackcnt = 0;

    function automatic void finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endfunction

    function automatic void exp_bus(input logic [1:0] op, input logic [AW-1:0] a);
        expq.push_back('{kind: 2'd0, op: op, addr: a, hit: 1'b0});
    endfunction
    function automatic void exp_done(input logic h);
        expq.push_back('{kind: 2'd1, op: 2'd0, addr: '0, hit: h});
    endfunction
    function automatic void exp_sup();
        expq.push_back('{kind: 2'd2, op: 2'd0, addr: '0, hit: 1'b0});
    endfunction

    function automatic void compare(input ev_t got);
        ev_t want;
        nvec++;
        if (expq.size() == 0) begin
            nbad++;
            $display("FAIL %s: unexpected event kind=%0d op=%0d addr=%h hit=%0d, expected none",
                     cur_req, got.kind, got.op, got.addr, got.hit);
            return;
        end
        want = expq.pop_front();
        if (got != want) begin
            nbad++;
            $display("FAIL %s: got kind=%0d op=%0d addr=%h hit=%0d, expected kind=%0d op=%0d addr=%h hit=%0d",
                     cur_req, got.kind, got.op, got.addr, got.hit,
                     want.kind, want.op, want.addr, want.hit);
        end
    endfunction

    // Monitor and bus responder: compare events, acknowledge after one wait cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (snp_supply || snp_mem_upd)
                    compare('{kind: 2'd2, op: {1'b0, snp_supply ^ snp_mem_upd}, addr: '0, hit: 1'b0});
                if (bus_req && !open) begin
                    compare('{kind: 2'd0, op: bus_op, addr: bus_addr, hit: 1'b0});
                    open = 1'b1;
                    ackcnt = 0;
                end
                if (cpu_done)
                    compare('{kind: 2'd1, op: 2'd0, addr: '0, hit: cpu_hit});
            end
            if (open) begin
                if (ackcnt == 1) begin bus_ack = 1'b1; open = 1'b0; end
                else begin bus_ack = 1'b0; ackcnt++; end
            end else begin
                bus_ack = 1'b0;
            end
        end
    end

    task automatic settle();
        repeat (3) @(negedge clk);
        while (expq.size() != 0) begin
            ev_t w = expq.pop_front();
            nvec++;
            nbad++;
            $display("FAIL %s: event kind=%0d op=%0d addr=%h never appeared (actual none)",
                     cur_req, w.kind, w.op, w.addr);
        end
    endtask

    task automatic cpu_go(input logic we, input logic [AW-1:0] a);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a;
        do @(negedge clk); while (!cpu_done);
        cpu_req = 1'b0;
        settle();
    endtask

    task automatic snoop(input logic [1:0] op, input logic [AW-1:0] a);
        @(negedge clk);
        snp_valid = 1'b1; snp_op = op; snp_addr = a;
        @(negedge clk);
        snp_valid = 1'b0;
        settle();
    endtask

    task automatic race(input logic [1:0] op, input logic [AW-1:0] a, input logic we);
        @(negedge clk);
        snp_valid = 1'b1; snp_op = op; snp_addr = a;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a;
        @(negedge clk);
        snp_valid = 1'b0;
        while (!cpu_done) @(negedge clk);
        cpu_req = 1'b0;
        settle();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: run did not end, actual hung, expected completion");
        finish_run();
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);
        nvec++;
        if (bus_req || cpu_done || snp_supply) begin
            nbad++;
            $display("FAIL R1: outputs after reset %b%b%b, expected 000", bus_req, cpu_done, snp_supply);
        end
        rst_n = 1'b1;

        cur_req = "R1"; exp_bus(2'd1, 12'h010); exp_done(1'b0); cpu_go(1'b0, 12'h010);
        cur_req = "R2"; exp_done(1'b1); cpu_go(1'b0, 12'h010);
        cur_req = "R3"; exp_bus(2'd1, 12'h110); exp_done(1'b0); cpu_go(1'b0, 12'h110);
        exp_bus(2'd1, 12'h010); exp_done(1'b0); cpu_go(1'b0, 12'h010);

        cur_req = "R5"; exp_bus(2'd3, 12'h023); exp_done(1'b0); cpu_go(1'b1, 12'h023);
        cur_req = "R8"; exp_sup(); snoop(2'd0, 12'h023);
        snoop(2'd0, 12'h023);                       // Valid now: no response
        cur_req = "R2"; exp_done(1'b1); cpu_go(1'b0, 12'h023);

        cur_req = "R4"; exp_bus(2'd3, 12'h023); exp_done(1'b0); cpu_go(1'b1, 12'h023);
        cur_req = "R6"; exp_bus(2'd3, 12'h023); exp_done(1'b0); cpu_go(1'b1, 12'h023);
        cur_req = "R9"; exp_sup(); snoop(2'd1, 12'h023);
        exp_bus(2'd1, 12'h023); exp_done(1'b0); cpu_go(1'b0, 12'h023);

        cur_req = "R7"; snoop(2'd2, 12'h010);
        exp_bus(2'd1, 12'h010); exp_done(1'b0); cpu_go(1'b0, 12'h010);
        snoop(2'd2, 12'h110);                       // other tag, same index
        exp_done(1'b1); cpu_go(1'b0, 12'h010);
        snoop(2'd1, 12'h010);                       // write to Valid: drop, no supply
        exp_bus(2'd1, 12'h010); exp_done(1'b0); cpu_go(1'b0, 12'h010);

        cur_req = "R10"; exp_bus(2'd3, 12'h045); exp_done(1'b0); cpu_go(1'b1, 12'h045);
        exp_bus(2'd2, 12'h045); exp_bus(2'd1, 12'h145); exp_done(1'b0); cpu_go(1'b0, 12'h145);
        exp_bus(2'd3, 12'h145); exp_done(1'b0); cpu_go(1'b1, 12'h145);
        exp_bus(2'd2, 12'h145); exp_bus(2'd3, 12'h055); exp_done(1'b0); cpu_go(1'b1, 12'h055);

        cur_req = "R11"; exp_bus(2'd1, 12'h010); exp_done(1'b0); race(2'd2, 12'h010, 1'b0);
        exp_bus(2'd3, 12'h067); exp_done(1'b0); cpu_go(1'b1, 12'h067);
        exp_sup(); exp_done(1'b1); race(2'd0, 12'h067, 1'b0);

        finish_run();
    end

endmodule